// File: doc/BRIEF.md
# Bus-Mapped 16-bit Reloadable Down-Counter Timer

This block is a single 16-bit down-counting timer reached over a simple single-cycle register bus. Software places a start value in the reload register, picks a clock divide ratio and a run mode in the control word, and then sets the enable bit. On each divided tick the count drops by one. When a tick arrives while the count is already zero, the timer expires. An expiry raises an interrupt status bit, which also drives the `irq` output. After an expiry, the count either restarts from the reload value or wraps around to 0xFFFF.

The bus has four word registers, selected by address bits [3:2]:

- reload value at 0x0
- current count at 0x4, read-only
- control at 0x8
- interrupt clear at 0xC, write-only

Control word layout:

- bits [4:2] choose the divide ratio
- bit 6 chooses the mode
- bit 7 enables counting
- bit 8 reports the interrupt status
- every other bit reads as zero

A write of any data value to the clear register drops the interrupt status. If an expiry happens in the same cycle as that write, the expiry wins.

Top module: `tmr16_bus`

## Requirements
- R1: After reset the reload value, the count, every control field and `irq` are all zero.
- R2: The reload and count registers are 16 bits wide and read zero in bits [31:16]. A write to offset 0x4 leaves the count unchanged.
- R3: A write to offset 0x0 loads the written low 16 bits into both the reload register and the count on the same clock edge. It also restarts the divider from zero.
- R4: While control bit 7 (enable) is 0, the count holds and the divider stays at zero.
- R5: A write of any data value to offset 0xC clears the interrupt status (control bit 8) and `irq` on the next edge.
- R6: When an expiry and a clear write fall in the same cycle, the interrupt status is set.
- R7: Control bits [4:2] select the divide ratio D: code 0 gives 1, code 1 gives 16, code 2 gives 256, code 3 gives 2, code 4 gives 8, code 5 gives 32, code 6 gives 128, and code 7 gives 1024. With reload L, the first expiry occurs D*(L+1) clock edges after the edge that sets enable.
- R8: With control bit 6 set to 1 (periodic mode), the count takes the reload value at expiry.
- R9: With control bit 6 set to 0 (free-run mode), the count becomes 0xFFFF at expiry.
- R10: The control word reads back bits [4:2], bit 6 and bit 7 as written, bit 8 as the interrupt status, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read strobe, otherwise zero |
| irq | output | 1 | Interrupt, equal to the interrupt status bit |

## Verification
The assertions assume that the bus inputs are known, two-state values whenever the strobe is high, and that every access lasts exactly one cycle. The bench drives all bus inputs from tasks on the falling clock edge. It returns the strobe to zero after each access and never overlaps two accesses. The priority check assumes that a clear write can be placed exactly on the expiry edge. The bench does this by counting edges from the enabling write with the divide ratio set to 1.

// File: rtl/tmr16_bus.sv
module tmr16_bus #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] reload_q, cnt_q;
  logic [PS_W-1:0]  ps_q, ps_mask;
  logic [2:0]       div_sel;
  logic             periodic, run, irq_q;

  wire wr        = bus_en & bus_we;
  wire reload_wr = wr && bus_addr[3:2] == 2'd0;
  wire ctrl_wr   = wr && bus_addr[3:2] == 2'd2;
  wire clr_wr    = wr && bus_addr[3:2] == 2'd3;
  wire unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};

  always_comb begin
    case (div_sel)
      3'd1:    ps_mask = PS_W'(15);
      3'd2:    ps_mask = PS_W'(255);
      3'd3:    ps_mask = PS_W'(1);
      3'd4:    ps_mask = PS_W'(7);
      3'd5:    ps_mask = PS_W'(31);
      3'd6:    ps_mask = PS_W'(127);
      3'd7:    ps_mask = PS_W'(1023);
      default: ps_mask = '0;
    endcase
  end

  wire tick   = run && ((ps_q & ps_mask) == ps_mask);
  wire expire = tick && !reload_wr && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ps_q <= '0;
    else if (!run || reload_wr) ps_q <= '0;
    else                        ps_q <= ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (reload_wr) begin
      reload_q <= bus_wdata[CNT_W-1:0];
      cnt_q    <= bus_wdata[CNT_W-1:0];
    end else if (tick) begin
      if (cnt_q == '0) cnt_q <= periodic ? reload_q : CNT_MAX;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel  <= '0;
      periodic <= 1'b0;
      run      <= 1'b0;
    end else if (ctrl_wr) begin
      div_sel  <= bus_wdata[4:2];
      periodic <= bus_wdata[6];
      run      <= bus_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (expire) irq_q <= 1'b1;
    else if (clr_wr) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      case (bus_addr[3:2])
        2'd0: bus_rdata[CNT_W-1:0] = reload_q;
        2'd1: bus_rdata[CNT_W-1:0] = cnt_q;
        2'd2: bus_rdata[8:0] = {irq_q, run, periodic, 1'b0, div_sel, 2'b00};
        default: bus_rdata = '0;
      endcase
    end
  end

  a_r3_reload_load: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (cnt_q == $past(bus_wdata[CNT_W-1:0]) && ps_q == '0));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload_wr) |=> ($stable(cnt_q) && ps_q == '0));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !irq);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);
  a_r2_count_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr[3:2] == 2'd1 && !run) |=> $stable(cnt_q));
endmodule

// File: tb/sim_tmr16_bus.sv
module sim_tmr16_bus;
  localparam int CLK_HALF = 5;
  localparam int LIMIT    = 150000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  tmr16_bus u0 (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #CLK_HALF clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  function automatic int div_of(input int c);
    int sh[8] = '{0, 4, 8, 1, 3, 5, 7, 10};
    return 1 << sh[c];
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    logic [31:0] v, v2;
    int n;
    #(CLK_HALF*3) rst_n = 1;

    // R1 reset state
    rd(4'h0, v); chk(v == 0, "R1 reload", v, 0);
    rd(4'h4, v); chk(v == 0, "R1 count", v, 0);
    rd(4'h8, v); chk(v == 0, "R1 ctrl", v, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R10 control readback
    wr(4'h8, 32'hFFFF_FF7F);
    rd(4'h8, v); chk(v == 32'h5C, "R10 ctrl mask", v, 32'h5C);
    wr(4'h8, 0);

    // R2 upper bits zero, count read-only
    wr(4'h0, 32'hABCD_1234);
    rd(4'h0, v); chk(v == 32'h1234, "R2 reload upper", v, 32'h1234);
    wr(4'h4, 32'h0000_5555);
    rd(4'h4, v); chk(v == 32'h1234, "R2 count ro", v, 32'h1234);

    // R4 hold while disabled
    repeat (20) @(posedge clk);
    rd(4'h4, v); chk(v == 32'h1234, "R4 hold", v, 32'h1234);

    // R7/R8 sweep over all divide codes, several reloads
    for (int c = 0; c < 8; c++) begin
      for (int l = 0; l < 3; l++) begin
        wr(4'h8, 0); wr(4'hC, 32'h0);
        wr(4'h0, l);
        wr(4'h8, 32'h0C0 | (c << 2));
        n = 0;
        while (!irq && n < 5000) begin @(posedge clk); #1; n++; end
        chk(n == div_of(c) * (l + 1), "R7 expiry edge", n, div_of(c) * (l + 1));
        rd(4'h4, v); chk(v == l, "R8 periodic reload", v, l);
      end
    end

    // R9 free-run wrap, with divide 1024 so count stays put
    wr(4'h8, 0); wr(4'hC, 32'hDEAD_BEEF);
    chk(irq == 0, "R5 clear any data", irq, 0);
    wr(4'h0, 1);
    wr(4'h8, 32'h080 | (7 << 2));
    n = 0;
    while (!irq && n < 5000) begin @(posedge clk); #1; n++; end
    rd(4'h4, v); chk(v == 32'hFFFF, "R9 free wrap", v, 32'hFFFF);
    rd(4'h8, v); chk(v[8] == 1, "R5 status bit set", v[8], 1);
    wr(4'hC, 32'h0);
    rd(4'h8, v); chk(v[8] == 0, "R5 status cleared", v[8], 0);

    // R3 reload write while running loads count and restarts divider
    wr(4'h0, 32'h0777);
    rd(4'h4, v); chk(v == 32'h0777, "R3 immediate load", v, 32'h0777);
    repeat (1000) @(posedge clk);
    rd(4'h4, v2); chk(v2 == 32'h0777, "R3 divider restart", v2, 32'h0777);

    // R6 set wins over same-cycle clear (divide 1, reload 3 -> expiry 4 edges)
    wr(4'h8, 0); wr(4'hC, 0);
    wr(4'h0, 3);
    wr(4'h8, 32'h0C0);
    repeat (3) @(posedge clk);
    wr(4'hC, 32'h1);
    chk(irq == 1, "R6 set priority", irq, 1);
    wr(4'hC, 32'h1);
    chk(irq == 0, "R5 later clear", irq, 0);

    done = 1;
    finish_run();
  end

  initial begin
    wait (cyc >= LIMIT);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      finish_run();
    end
  end
endmodule